// File: doc/BRIEF.md
# Manchester Receive Decoder with Pattern Acquisition

This block turns a single-bit Manchester-coded receive line into NRZ bits. The line is sampled by a local clock that runs at a fixed multiple of the nominal bit rate (16 by default). The local clock has no phase or frequency relation to the sender. The line passes through a flop synchroniser and an edge detector. A phase counter then measures, in samples, how far each transition lies from the last accepted mid-cell transition.

While hunting, the block tries each transition as a candidate mid-cell reference. It builds up a short history of decoded bits and declares lock once the last four bits read 1, 0, 1, 0. The falling mid-cell transition of that second zero becomes the phase reference. When locked, the block samples the line a quarter bit after each expected cell boundary to recover the bit. It emits that bit with a one-clock valid pulse when the following mid-cell transition arrives, and it re-centres the phase counter on that transition. Any transition that lies a quarter bit or more from both nominal positions raises an error pulse and marks the message bad. When the mid-cell transitions stop, the block drops lock and goes back to hunting.

Top module: `manch_rx`

## Requirements
- R1: After reset, rxLock, rxValid, codeErr and msgBad are all 0.
- R2: A rising mid-cell transition decodes as 1 and a falling one as 0. rxLock rises only after the mid-cell transitions of four consecutive cells decode as 1, 0, 1, 0, and it follows the falling transition of the second 0. These four bits are never output.
- R3: When locked, each bit is presented on rxData with a valid pulse exactly one clock wide, in line order. The bit value is the inverse of the line level sampled 3/4 of a bit (12 samples) after the previous accepted mid-cell transition.
- R4: A mid-cell transition 13 to 19 samples after the previous accepted one is accepted. It produces a bit and re-centres the phase, so cells of 15 or 17 samples decode correctly.
- R5: A cell-boundary transition 5 to 11 samples after the last accepted mid-cell transition raises no error.
- R6: When locked, a transition at any other phase (displaced by 4 samples or more) gives a one-clock codeErr pulse and sets msgBad. msgBad stays set, even after lock is lost, until the next lock is acquired.
- R7: When locked, if no accepted mid-cell transition arrives within 24 samples of the last one, rxLock falls and no further bits are output until a new lock.
- R8: A message whose last bit is a single 0, followed by an idle line, delivers that 0 before lock is lost.
- R9: Lock is acquired from any starting phase and any idle level. Alternating bits beyond the first four are output as data.
- R10: While not locked, rxValid and codeErr stay 0, and patterns without 1, 0, 1, 0 (such as 1,1,0,0 repeated) never give lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OVS samples per nominal bit |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Manchester-coded receive line, asynchronous |
| rxData | output | 1 | Recovered bit, valid with rxValid |
| rxValid | output | 1 | One-clock pulse per recovered bit |
| rxLock | output | 1 | Carrier locked: acquisition done, transitions being tracked |
| codeErr | output | 1 | One-clock pulse for a misplaced transition while locked |
| msgBad | output | 1 | Sticky flag: current message contained a decode error |

## Verification
The assertions assume the receive line is a clean digital level that holds each value for several samples. They also assume that, while locked, accepted mid-cell transitions never come closer than 13 samples apart. This is what makes the valid strobe a single clock wide. The stimulus builds every cell from two half-cell durations, each at least 4 samples. A displacement is applied to at most one transition at a time and never exceeds 4 samples. The nominal grid resumes immediately afterwards, so every accepted transition stays inside the windows the properties rely on.

// File: rtl/manch_rx_pkg.sv
package manch_rx_pkg;

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_TRACK = 1'b1
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntRestart;  // restart phase count at this transition
    logic histLoad;    // start a new candidate history with this transition
    logic histShift;   // append this transition's bit to the history
    logic emitBit;     // present the strobed bit on the output
  } rxCtrl_t;

  // observations from datapath to control
  typedef struct packed {
    logic edgeSeen;
    logic edgeRise;
    logic inMid;
    logic inBound;
    logic timedOut;
    logic preambleHit;
  } rxStat_t;

endpackage

// File: rtl/manch_rx_datapath.sv
module manch_rx_datapath
  import manch_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_LEN     = 4,
  parameter logic [PRE_LEN-1:0] PRE_PAT = 4'b1010
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    rxLine,
  input  rxCtrl_t ctrl,
  output rxStat_t stat,
  output logic    rxData,
  output logic    rxValid
);

  localparam int HALF    = OVS / 2;
  localparam int QTR     = OVS / 4;
  localparam int TIMEOUT = OVS + HALF;
  localparam int STROBE  = HALF + QTR;
  localparam int CW      = $clog2(TIMEOUT + 1);

  localparam logic [CW-1:0] MID_LO   = CW'(OVS - QTR);
  localparam logic [CW-1:0] MID_HI   = CW'(OVS + QTR);
  localparam logic [CW-1:0] BND_LO   = CW'(HALF - QTR);
  localparam logic [CW-1:0] BND_HI   = CW'(HALF + QTR);
  localparam logic [CW-1:0] LIMIT    = CW'(TIMEOUT);
  localparam logic [CW-1:0] STROBE_P = CW'(STROBE);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lineQ;
  logic                   linePrev;
  logic [CW-1:0]          phaseCnt;
  logic                   bitSample;
  logic [PRE_LEN-1:0]     hist;

  // input synchroniser
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= rxLine;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], rxLine};
      end
    end
  endgenerate

  assign lineQ = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) linePrev <= 1'b0;
    else       linePrev <= lineQ;
  end

  // edge detection and phase windows
  always_comb begin
    stat.edgeSeen    = lineQ ^ linePrev;
    stat.edgeRise    = lineQ & ~linePrev;
    stat.inMid       = (phaseCnt > MID_LO) && (phaseCnt < MID_HI);
    stat.inBound     = (phaseCnt > BND_LO) && (phaseCnt < BND_HI);
    stat.timedOut    = (phaseCnt == LIMIT);
    stat.preambleHit = ({hist[PRE_LEN-2:0], stat.edgeRise} == PRE_PAT);
  end

  // phase counter: samples since the reference transition, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                phaseCnt <= LIMIT;
    else if (ctrl.cntRestart) phaseCnt <= CW'(1);
    else if (phaseCnt != LIMIT) phaseCnt <= phaseCnt + CW'(1);
  end

  // quarter-bit-after-boundary data strobe
  always_ff @(posedge clk) begin
    if (!rstN)                     bitSample <= 1'b0;
    else if (phaseCnt == STROBE_P) bitSample <= ~lineQ;
  end

  // acquisition history
  always_ff @(posedge clk) begin
    if (!rstN)               hist <= '0;
    else if (ctrl.histLoad)  hist <= {{(PRE_LEN-1){1'b0}}, stat.edgeRise};
    else if (ctrl.histShift) hist <= {hist[PRE_LEN-2:0], stat.edgeRise};
  end

  // output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxData  <= 1'b0;
    end else begin
      rxValid <= ctrl.emitBit;
      if (ctrl.emitBit) rxData <= bitSample;
    end
  end

  // R3
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R4
  valid_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(stat.inMid && stat.edgeSeen));

  // R7
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseCnt <= LIMIT);

endmodule

// File: rtl/manch_rx_control.sv
module manch_rx_control
  import manch_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  rxStat_t stat,
  output rxCtrl_t ctrl,
  output logic    locked,
  output logic    codeErr,
  output logic    msgBad
);

  rxState_t state;
  rxState_t nextState;
  logic     setErr;

  always_comb begin
    ctrl      = '0;
    nextState = state;
    setErr    = 1'b0;
    unique case (state)
      ST_HUNT: begin
        if (stat.edgeSeen) begin
          ctrl.cntRestart = 1'b1;
          if (stat.inMid) begin
            ctrl.histShift = 1'b1;
            if (stat.preambleHit) nextState = ST_TRACK;
          end else begin
            ctrl.histLoad = 1'b1;
          end
        end
      end
      ST_TRACK: begin
        if (stat.timedOut) begin
          nextState = ST_HUNT;
        end else if (stat.edgeSeen) begin
          if (stat.inMid) begin
            ctrl.cntRestart = 1'b1;
            ctrl.emitBit    = 1'b1;
          end else if (!stat.inBound) begin
            setErr = 1'b1;
          end
        end
      end
      default: nextState = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      codeErr <= 1'b0;
      msgBad  <= 1'b0;
    end else begin
      state   <= nextState;
      codeErr <= setErr;
      if (state == ST_HUNT && nextState == ST_TRACK) msgBad <= 1'b0;
      else if (setErr)                               msgBad <= 1'b1;
    end
  end

  assign locked = (state == ST_TRACK);

  // R2
  lock_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(stat.edgeSeen && !stat.edgeRise));

  // R7
  carrier_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(stat.timedOut));

  // R6
  bad_after_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msgBad) |-> codeErr);

  // R10
  err_when_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeErr |-> locked);

endmodule

// File: rtl/manch_rx.sv
module manch_rx
  import manch_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxLine,
  output logic rxData,
  output logic rxValid,
  output logic rxLock,
  output logic codeErr,
  output logic msgBad
);

  rxCtrl_t ctrl;
  rxStat_t stat;

  manch_rx_datapath #(
    .OVS        (OVS),
    .SYNC_STAGES(SYNC_STAGES),
    .PRE_LEN    (4),
    .PRE_PAT    (4'b1010)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .rxLine (rxLine),
    .ctrl   (ctrl),
    .stat   (stat),
    .rxData (rxData),
    .rxValid(rxValid)
  );

  manch_rx_control u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .stat   (stat),
    .ctrl   (ctrl),
    .locked (rxLock),
    .codeErr(codeErr),
    .msgBad (msgBad)
  );

  // R10
  valid_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> rxLock);

endmodule

// File: tb/sim_manch_rx.sv
module sim_manch_rx;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b0;
  logic rxData, rxValid, rxLock, codeErr, msgBad;

  int total = 0;
  int bad = 0;
  int errPulses = 0;
  bit finished = 1'b0;
  bit expQ[$];
  string curReq = "R3";

  always #5 clk = ~clk;

  manch_rx #(.OVS(16), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .rxLine(rxLine),
    .rxData(rxData), .rxValid(rxValid), .rxLock(rxLock),
    .codeErr(codeErr), .msgBad(msgBad)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected bits as the design produces them
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (rxValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, curReq, "unexpected bit", int'(rxData), -1);
        end else begin
          bit e;
          e = expQ.pop_front();
          check(rxData == e, curReq, "decoded bit", int'(rxData), int'(e));
        end
      end
      if (codeErr) errPulses++;
    end
  end

  task automatic hold(input bit lvl, input int n);
    rxLine = lvl;
    repeat (n) @(negedge clk);
  endtask

  // 1 = low then high; h1/h2 are the half-cell lengths in samples
  task automatic sendBit(input bit b, input int h1, input int h2, input bit push);
    if (push) expQ.push_back(b);
    hold(!b, h1);
    hold(b, h2);
  endtask

  task automatic preamble(input int n, input int h1, input int h2);
    for (int i = 0; i < n; i++) sendBit((i % 2) == 0, h1, h2, i >= 4);
  endtask

  task automatic endMsg(input string req);
    repeat (40) @(negedge clk);
    check(rxLock == 1'b0, "R7", "lock after idle", int'(rxLock), 0);
    check(expQ.size() == 0, req, "bits left undelivered", expQ.size(), 0);
  endtask

  initial begin
    int errBase;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(rxLock == 1'b0, "R1", "rxLock at reset", int'(rxLock), 0);
    check(rxValid == 1'b0, "R1", "rxValid at reset", int'(rxValid), 0);
    check(codeErr == 1'b0, "R1", "codeErr at reset", int'(codeErr), 0);
    check(msgBad == 1'b0, "R1", "msgBad at reset", int'(msgBad), 0);
    rstN = 1'b1;

    // R2/R3 nominal message
    curReq = "R3";
    hold(1'b0, 20);
    preamble(4, 8, 8);
    check(rxLock == 1'b1, "R2", "lock after 1010", int'(rxLock), 1);
    foreach (expQ[i]) check(1'b0, "R2", "preamble queued", 1, 0);
    sendBit(1, 8, 8, 1); sendBit(1, 8, 8, 1); sendBit(0, 8, 8, 1);
    sendBit(0, 8, 8, 1); sendBit(1, 8, 8, 1); sendBit(0, 8, 8, 1);
    sendBit(1, 8, 8, 1); sendBit(1, 8, 8, 1); sendBit(0, 8, 8, 1);
    sendBit(1, 8, 8, 1);
    check(msgBad == 1'b0, "R5", "msgBad clean message", int'(msgBad), 0);
    endMsg("R3");
    check(errPulses == 0, "R5", "error pulses clean message", errPulses, 0);

    // R9 idle high, odd phase, longer preamble
    curReq = "R9";
    hold(1'b1, 23);
    preamble(6, 8, 8);
    sendBit(0, 8, 8, 1); sendBit(1, 8, 8, 1); sendBit(1, 8, 8, 1);
    sendBit(0, 8, 8, 1);
    endMsg("R9");

    // R4 slow and fast bit cells
    curReq = "R4";
    hold(1'b0, 20);
    preamble(4, 8, 9);
    check(rxLock == 1'b1, "R4", "lock with 17-sample cells", int'(rxLock), 1);
    sendBit(1, 8, 9, 1); sendBit(0, 8, 9, 1); sendBit(0, 8, 9, 1);
    sendBit(1, 8, 9, 1); sendBit(1, 8, 9, 1);
    endMsg("R4");
    hold(1'b0, 20);
    preamble(4, 7, 8);
    check(rxLock == 1'b1, "R4", "lock with 15-sample cells", int'(rxLock), 1);
    sendBit(0, 7, 8, 1); sendBit(1, 7, 8, 1); sendBit(1, 7, 8, 1);
    sendBit(0, 7, 8, 1); sendBit(0, 7, 8, 1);
    endMsg("R4");

    // R4/R5 displacements of 3 samples are tolerated
    curReq = "R5";
    errBase = errPulses;
    hold(1'b0, 20);
    preamble(4, 8, 8);
    sendBit(1, 8, 8, 1);
    sendBit(1, 11, 5, 1);   // mid +3, then boundary -3
    sendBit(1, 8, 8, 1);
    sendBit(0, 5, 11, 1);   // mid -3, then boundary +3
    sendBit(0, 5, 8, 1);
    sendBit(0, 11, 5, 1);   // mid +3, then boundary -3
    sendBit(0, 11, 8, 1);
    sendBit(1, 8, 8, 1);
    check(msgBad == 1'b0, "R5", "msgBad after 3-sample shifts", int'(msgBad), 0);
    check(errPulses == errBase, "R4", "errors after 3-sample shifts", errPulses - errBase, 0);
    endMsg("R5");

    // R6 boundary displaced by 4: error, data still decoded
    curReq = "R6";
    errBase = errPulses;
    hold(1'b0, 20);
    preamble(4, 8, 8);
    sendBit(1, 8, 4, 1);
    sendBit(1, 12, 8, 1);
    sendBit(0, 8, 8, 1);
    sendBit(1, 8, 8, 1);
    check(errPulses == errBase + 1, "R6", "error pulses for 4-sample shift", errPulses - errBase, 1);
    check(msgBad == 1'b1, "R6", "msgBad after error", int'(msgBad), 1);
    endMsg("R6");
    check(msgBad == 1'b1, "R6", "msgBad held after lock loss", int'(msgBad), 1);

    // R8 single trailing zero, also clears msgBad on new lock (R6)
    curReq = "R8";
    hold(1'b0, 20);
    preamble(4, 8, 8);
    check(msgBad == 1'b0, "R6", "msgBad cleared on new lock", int'(msgBad), 0);
    sendBit(0, 8, 8, 1);
    endMsg("R8");

    // R6/R7 mid transition displaced by 4: error, lock lost, no more bits
    curReq = "R7";
    errBase = errPulses;
    hold(1'b0, 20);
    preamble(4, 8, 8);
    sendBit(1, 8, 8, 1);
    sendBit(1, 12, 4, 0);
    sendBit(1, 8, 8, 0); sendBit(1, 8, 8, 0); sendBit(1, 8, 8, 0);
    check(errPulses == errBase + 1, "R6", "error for late mid transition", errPulses - errBase, 1);
    check(rxLock == 1'b0, "R7", "lock lost after bad mid transition", int'(rxLock), 0);
    endMsg("R7");

    // R10 no lock on 1100 patterns
    curReq = "R10";
    errBase = errPulses;
    hold(1'b0, 20);
    for (int k = 0; k < 3; k++) begin
      sendBit(1, 8, 8, 0); sendBit(1, 8, 8, 0);
      sendBit(0, 8, 8, 0); sendBit(0, 8, 8, 0);
      check(rxLock == 1'b0, "R10", "lock on 1100 pattern", int'(rxLock), 0);
    end
    check(errPulses == errBase, "R10", "errors while hunting", errPulses - errBase, 0);
    endMsg("R10");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog (R7) actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule